// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block steps one or more DDR3 memory channels from power-on to the point where ordinary traffic may start. A single start pulse sets an init-enable flag. The block then waits for that flag to be acknowledged and holds the DRAM reset low for the required time. It releases reset, waits again, and raises the clock-enable pin while no command is being presented. Every wait is counted in controller clocks, derived from a parameter that gives the number of clocks per 10 ns.

Once the pins are up, the sequencer walks the channels in ascending order and skips any channel that holds no memory. Inside a channel it visits the present chip selects from lowest to highest. For each one it asks an external mode-register-command unit to send the whole mode-register set, then allows time for the DLL to relock. With registered DIMMs every present rank is programmed. With unbuffered DIMMs only the lowest present rank is programmed. Each channel finishes with two ZQ long-calibration requests. The block then clears the init-enable flag, waits for the acknowledge, pulses done and returns to idle.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: After reset, busy, done, the DRAM reset pin, clock enable, init-enable and the command request are all low.
- R2: When start is taken in idle, the block raises init-enable and drives the DRAM reset pin and clock enable low. It then waits for init_ack_i. The DRAM reset pin rises exactly T_RST_10NS*CLK_PER_10NS clocks after the clock edge that samples the acknowledge.
- R3: Clock enable rises exactly T_CKE_10NS*CLK_PER_10NS clocks after the DRAM reset pin rises. Clock enable is never high while the DRAM reset pin is low.
- R4: No command request is made while clock enable is low. The first request comes at least T_MRS_10NS*CLK_PER_10NS clocks, and at most three clocks more than that, after clock enable rises.
- R5: Channels are served in ascending order. A channel whose bit in ch_populated_i is clear receives no request, whatever its chip-select mask holds.
- R6: A mode-register request uses cmd_op_o=0 and is addressed to a chip select whose bit (bit ch*NUM_CS+cs of cs_present_i) is set. With registered_i=1, every present chip select of the channel is requested once, in ascending order.
- R7: With registered_i=0, only the lowest present chip select of each channel gets a mode-register request.
- R8: After a mode-register request completes, the next request starts no sooner than T_DLL_10NS*CLK_PER_10NS clocks later, and at most three clocks more than that.
- R9: After its ranks, each served channel gets two ZQ long-calibration requests (cmd_op_o=1), the first to chip select 0 and the second to chip select 1. This also applies to a populated channel that has no present chip select.
- R10: A request stays high, with op, channel and chip select unchanged, until the clock edge that samples cmd_done_i.
- R11: After the last channel, init-enable falls. Once init_ack_i is seen, done pulses for one clock and busy falls. The DRAM reset pin and clock enable stay high.
- R12: A start pulse while busy is ignored. The run in progress continues unchanged and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, taken only in idle |
| ch_populated_i | input | NUM_CH | One bit per channel that holds memory |
| cs_present_i | input | NUM_CH*NUM_CS | Chip-select present bits, channel-major |
| registered_i | input | 1 | 1 = registered or load-reduced DIMMs, 0 = unbuffered |
| init_ack_i | input | 1 | Acknowledge of each init-enable change |
| cmd_done_i | input | 1 | Command unit has finished the requested command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse at completion |
| dram_rst_n_o | output | 1 | DRAM reset pin, active low |
| cke_o | output | 1 | DRAM clock enable |
| init_en_o | output | 1 | Init-enable flag toward the controller |
| cmd_req_o | output | 1 | Command request, held until cmd_done_i |
| cmd_op_o | output | 1 | 0 = full mode-register set, 1 = ZQ long calibration |
| cmd_ch_o | output | max(1,clog2(NUM_CH)) | Target channel |
| cmd_cs_o | output | max(1,clog2(NUM_CS)) | Target chip select |

## Verification
The channel and chip-select checks assume that ch_populated_i, cs_present_i and registered_i are held steady for the whole of a run. The bench sets them only while the block is idle and leaves them alone until done. The hold check on requests assumes that cmd_done_i is raised only while a request is pending, for a single clock. The bench's command responder answers only an outstanding request and always drops done on the next clock. The acknowledge responder likewise pulses init_ack_i once for each change of init-enable.

// File: rtl/ddr3_pwrup_pkg.sv
package ddr3_pwrup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN_SET,
    ST_W_RST,
    ST_W_CKE,
    ST_W_MRS,
    ST_CH_NEXT,
    ST_CS_NEXT,
    ST_MRS_REQ,
    ST_W_DLL,
    ST_ZQ_EVEN,
    ST_ZQ_ODD,
    ST_EN_CLR,
    ST_FIN
  } seq_state_e;

  // command kinds carried on cmd_op_o
  localparam logic OP_MRSET = 1'b0;
  localparam logic OP_ZQCL  = 1'b1;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/first_set_from.sv
module first_set_from #(
  parameter int N  = 8,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] from_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] qual;

  for (genvar g = 0; g < N; g++) begin : g_qual
    assign qual[g] = mask_i[g] && (from_i <= IW'(g));
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_pwrup_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int NUM_CS       = 8,
  parameter int CLK_PER_10NS = 4,
  parameter int T_RST_10NS   = 20000,
  parameter int T_CKE_10NS   = 50000,
  parameter int T_MRS_10NS   = 36,
  parameter int T_DLL_10NS   = 50000,
  localparam int CHW = idx_w(NUM_CH),
  localparam int CSW = idx_w(NUM_CS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [NUM_CH-1:0]        ch_populated_i,
  input  logic [NUM_CH*NUM_CS-1:0] cs_present_i,
  input  logic                     registered_i,
  input  logic                     init_ack_i,
  input  logic                     cmd_done_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     dram_rst_n_o,
  output logic                     cke_o,
  output logic                     init_en_o,
  output logic                     cmd_req_o,
  output logic                     cmd_op_o,
  output logic [CHW-1:0]           cmd_ch_o,
  output logic [CSW-1:0]           cmd_cs_o
);
  localparam int CHP     = $clog2(NUM_CH + 1);
  localparam int CSP     = $clog2(NUM_CS + 1);
  localparam int CYC_RST = T_RST_10NS * CLK_PER_10NS;
  localparam int CYC_CKE = T_CKE_10NS * CLK_PER_10NS;
  localparam int CYC_MRS = T_MRS_10NS * CLK_PER_10NS;
  localparam int CYC_DLL = T_DLL_10NS * CLK_PER_10NS;
  localparam int MAX_A   = (CYC_RST > CYC_CKE) ? CYC_RST : CYC_CKE;
  localparam int MAX_B   = (CYC_MRS > CYC_DLL) ? CYC_MRS : CYC_DLL;
  localparam int MAXC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = $clog2(MAXC + 1);

  logic rst_n_s;

  pwrup_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  seq_state_e      state_q, state_d;
  logic [CHW-1:0]  ch_cur_q, ch_cur_d;
  logic [CHP-1:0]  ch_ptr_q, ch_ptr_d;
  logic [CSW-1:0]  cs_cur_q, cs_cur_d;
  logic [CSP-1:0]  cs_ptr_q, cs_ptr_d;
  logic            pin_rstn_q, pin_rstn_d;
  logic            pin_cke_q, pin_cke_d;
  logic            en_q, en_d;

  logic            tmr_load;
  logic [TW-1:0]   tmr_val;
  logic            tmr_expired;

  pwrup_wait_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  // per-channel view of the chip-select masks
  logic [NUM_CS-1:0] cs_by_ch [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chmask
    assign cs_by_ch[c] = cs_present_i[c*NUM_CS +: NUM_CS];
  end

  logic [NUM_CS-1:0] cur_cs_mask;
  assign cur_cs_mask = cs_by_ch[ch_cur_q];

  logic           ch_found;
  logic [CHP-1:0] ch_idx;
  logic           cs_found;
  logic [CSP-1:0] cs_idx;

  first_set_from #(.N(NUM_CH), .IW(CHP)) u_ch_scan (
    .mask_i  (ch_populated_i),
    .from_i  (ch_ptr_q),
    .found_o (ch_found),
    .idx_o   (ch_idx)
  );

  first_set_from #(.N(NUM_CS), .IW(CSP)) u_cs_scan (
    .mask_i  (cur_cs_mask),
    .from_i  (cs_ptr_q),
    .found_o (cs_found),
    .idx_o   (cs_idx)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    ch_cur_d   = ch_cur_q;
    ch_ptr_d   = ch_ptr_q;
    cs_cur_d   = cs_cur_q;
    cs_ptr_d   = cs_ptr_q;
    pin_rstn_d = pin_rstn_q;
    pin_cke_d  = pin_cke_q;
    en_d       = en_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_EN_SET;
          en_d       = 1'b1;
          pin_rstn_d = 1'b0;
          pin_cke_d  = 1'b0;
        end
      end
      ST_EN_SET: begin
        if (init_ack_i) begin
          state_d  = ST_W_RST;
          tmr_load = 1'b1;
          tmr_val  = TW'(CYC_RST - 1);
        end
      end
      ST_W_RST: begin
        if (tmr_expired) begin
          state_d    = ST_W_CKE;
          pin_rstn_d = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = TW'(CYC_CKE - 1);
        end
      end
      ST_W_CKE: begin
        if (tmr_expired) begin
          state_d   = ST_W_MRS;
          pin_cke_d = 1'b1;
          tmr_load  = 1'b1;
          tmr_val   = TW'(CYC_MRS - 1);
        end
      end
      ST_W_MRS: begin
        if (tmr_expired) begin
          state_d  = ST_CH_NEXT;
          ch_ptr_d = '0;
        end
      end
      ST_CH_NEXT: begin
        if (ch_found) begin
          state_d  = ST_CS_NEXT;
          ch_cur_d = CHW'(ch_idx);
          cs_ptr_d = '0;
        end else begin
          state_d = ST_EN_CLR;
          en_d    = 1'b0;
        end
      end
      ST_CS_NEXT: begin
        if (cs_found) begin
          state_d  = ST_MRS_REQ;
          cs_cur_d = CSW'(cs_idx);
        end else begin
          state_d = ST_ZQ_EVEN;
        end
      end
      ST_MRS_REQ: begin
        if (cmd_done_i) begin
          state_d  = ST_W_DLL;
          tmr_load = 1'b1;
          tmr_val  = TW'(CYC_DLL - 1);
        end
      end
      ST_W_DLL: begin
        if (tmr_expired) begin
          if (registered_i) begin
            state_d  = ST_CS_NEXT;
            cs_ptr_d = CSP'(cs_cur_q) + CSP'(1);
          end else begin
            state_d = ST_ZQ_EVEN;
          end
        end
      end
      ST_ZQ_EVEN: begin
        if (cmd_done_i) state_d = ST_ZQ_ODD;
      end
      ST_ZQ_ODD: begin
        if (cmd_done_i) begin
          state_d  = ST_CH_NEXT;
          ch_ptr_d = CHP'(ch_cur_q) + CHP'(1);
        end
      end
      ST_EN_CLR: begin
        if (init_ack_i) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      ch_cur_q   <= '0;
      ch_ptr_q   <= '0;
      cs_cur_q   <= '0;
      cs_ptr_q   <= '0;
      pin_rstn_q <= 1'b0;
      pin_cke_q  <= 1'b0;
      en_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      ch_cur_q   <= ch_cur_d;
      ch_ptr_q   <= ch_ptr_d;
      cs_cur_q   <= cs_cur_d;
      cs_ptr_q   <= cs_ptr_d;
      pin_rstn_q <= pin_rstn_d;
      pin_cke_q  <= pin_cke_d;
      en_q       <= en_d;
    end
  end

  // outputs
  always_comb begin
    busy_o       = (state_q != ST_IDLE);
    done_o       = (state_q == ST_FIN);
    dram_rst_n_o = pin_rstn_q;
    cke_o        = pin_cke_q;
    init_en_o    = en_q;
    cmd_req_o    = (state_q == ST_MRS_REQ) || (state_q == ST_ZQ_EVEN) ||
                   (state_q == ST_ZQ_ODD);
    cmd_op_o     = (state_q == ST_MRS_REQ) ? OP_MRSET : OP_ZQCL;
    cmd_ch_o     = ch_cur_q;
    unique case (state_q)
      ST_ZQ_EVEN: cmd_cs_o = CSW'(0);
      ST_ZQ_ODD:  cmd_cs_o = CSW'(1);
      default:    cmd_cs_o = cs_cur_q;
    endcase
  end
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk #(
  parameter int NUM_CH = 2,
  parameter int NUM_CS = 8,
  localparam int CHW = ddr3_pwrup_pkg::idx_w(NUM_CH),
  localparam int CSW = ddr3_pwrup_pkg::idx_w(NUM_CS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        ch_populated_i,
  input logic [NUM_CH*NUM_CS-1:0] cs_present_i,
  input logic                     cmd_done_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     dram_rst_n_o,
  input logic                     cke_o,
  input logic                     init_en_o,
  input logic                     cmd_req_o,
  input logic                     cmd_op_o,
  input logic [CHW-1:0]           cmd_ch_o,
  input logic [CSW-1:0]           cmd_cs_o
);
  logic [NUM_CS-1:0] mask_by_ch [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_m
    assign mask_by_ch[c] = cs_present_i[c*NUM_CS +: NUM_CS];
  end

  logic [NUM_CS-1:0] tgt_mask;
  assign tgt_mask = mask_by_ch[cmd_ch_o];

  AST_CKE_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |-> dram_rst_n_o); // R3

  AST_REQ_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> (cke_o && init_en_o && busy_o)); // R4

  AST_CH_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> ch_populated_i[cmd_ch_o]); // R5

  AST_MRS_CS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !cmd_op_o) |-> tgt_mask[cmd_cs_o]); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !cmd_done_i) |=>
      (cmd_req_o && $stable(cmd_op_o) && $stable(cmd_ch_o) && $stable(cmd_cs_o))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R11

  AST_DONE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dram_rst_n_o && cke_o && !init_en_o)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cmd_req_o && !init_en_o)); // R12
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(.NUM_CH(NUM_CH), .NUM_CS(NUM_CS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ch_populated_i (ch_populated_i),
  .cs_present_i   (cs_present_i),
  .cmd_done_i     (cmd_done_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .dram_rst_n_o   (dram_rst_n_o),
  .cke_o          (cke_o),
  .init_en_o      (init_en_o),
  .cmd_req_o      (cmd_req_o),
  .cmd_op_o       (cmd_op_o),
  .cmd_ch_o       (cmd_ch_o),
  .cmd_cs_o       (cmd_cs_o)
);

// File: tb/ddr3_pwrup_seq_bench.sv
`timescale 1ns/1ps
module ddr3_pwrup_seq_bench;
  localparam int NCH = 2;
  localparam int NCS = 8;
  localparam int CPT = 2;
  localparam int TR = 5, TC = 7, TM = 3, TD = 4;
  localparam int CYC_R = TR*CPT, CYC_C = TC*CPT, CYC_M = TM*CPT, CYC_D = TD*CPT;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0;
  logic [NCH-1:0] ch_populated_i = '0;
  logic [NCH*NCS-1:0] cs_present_i = '0;
  logic registered_i = 0;
  logic init_ack_i = 0;
  logic cmd_done_i = 0;
  logic busy_o, done_o, dram_rst_n_o, cke_o, init_en_o, cmd_req_o, cmd_op_o;
  logic [0:0] cmd_ch_o;
  logic [2:0] cmd_cs_o;

  always #2 clk = ~clk;

  ddr3_pwrup_seq #(.NUM_CH(NCH), .NUM_CS(NCS), .CLK_PER_10NS(CPT),
    .T_RST_10NS(TR), .T_CKE_10NS(TC), .T_MRS_10NS(TM), .T_DLL_10NS(TD)) u_ddr3_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ch_populated_i(ch_populated_i),
    .cs_present_i(cs_present_i), .registered_i(registered_i), .init_ack_i(init_ack_i),
    .cmd_done_i(cmd_done_i), .busy_o(busy_o), .done_o(done_o), .dram_rst_n_o(dram_rst_n_o),
    .cke_o(cke_o), .init_en_o(init_en_o), .cmd_req_o(cmd_req_o), .cmd_op_o(cmd_op_o),
    .cmd_ch_o(cmd_ch_o), .cmd_cs_o(cmd_cs_o));

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor / responder state
  int ea_cyc, rst_rise, cke_rise, done_cnt, bad_req, unstable;
  int log_n;
  int log_op[32], log_ch[32], log_cs[32], log_start[32], log_done[32];
  logic prev_rst = 0, prev_cke = 0, en_seen = 0;
  int ack_wait = 0, cmd_wait = 0;
  int cur_start, cur_op, cur_ch, cur_cs;

  always @(negedge clk) begin
    if (dram_rst_n_o && !prev_rst) rst_rise = cyc;
    if (cke_o && !prev_cke) cke_rise = cyc;
    prev_rst = dram_rst_n_o;
    prev_cke = cke_o;
    if (done_o) done_cnt++;
    if (cmd_req_o && !cke_o) bad_req++;
    // acknowledge responder
    if (init_ack_i) init_ack_i = 0;
    else if (init_en_o != en_seen) begin
      en_seen = init_en_o;
      ack_wait = 3;
    end else if (ack_wait > 0) begin
      ack_wait--;
      if (ack_wait == 0) begin
        init_ack_i = 1;
        if (en_seen) ea_cyc = cyc + 1;
      end
    end
    // command responder
    if (cmd_done_i) cmd_done_i = 0;
    else if (cmd_req_o) begin
      if (cmd_wait == 0) begin
        cur_start = cyc; cur_op = int'(cmd_op_o); cur_ch = int'(cmd_ch_o); cur_cs = int'(cmd_cs_o);
      end else if (cur_op != int'(cmd_op_o) || cur_ch != int'(cmd_ch_o) || cur_cs != int'(cmd_cs_o))
        unstable++;
      if (cmd_wait == 2) begin
        cmd_done_i = 1;
        cmd_wait = 0;
        if (log_n < 32) begin
          log_op[log_n] = cur_op; log_ch[log_n] = cur_ch; log_cs[log_n] = cur_cs;
          log_start[log_n] = cur_start; log_done[log_n] = cyc;
        end
        log_n++;
      end else cmd_wait++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !dram_rst_n_o && !cke_o && !init_en_o && !cmd_req_o,
        "R1", "outputs after reset", int'({busy_o,done_o,dram_rst_n_o,cke_o,init_en_o,cmd_req_o}), 0);
  endtask

  // one full run with bench-computed expected command list
  task automatic t_run(string name, bit reg_dimm, logic [NCH-1:0] chm,
                       logic [NCH*NCS-1:0] csm, bit poke);
    int exp_op[32], exp_ch[32], exp_cs[32];
    int en = 0;
    int d0;
    bit rstreq;
    $display("scenario %s", name);
    ch_populated_i = chm; cs_present_i = csm; registered_i = reg_dimm;
    log_n = 0; bad_req = 0; unstable = 0; rst_rise = -1; cke_rise = -1;
    for (int c = 0; c < NCH; c++) begin
      if (chm[c]) begin
        for (int s = 0; s < NCS; s++) begin
          if (csm[c*NCS+s] && (reg_dimm || !rstreq)) begin
            exp_op[en] = 0; exp_ch[en] = c; exp_cs[en] = s; en++;
            rstreq = 1;
          end
        end
        rstreq = 0;
        exp_op[en] = 1; exp_ch[en] = c; exp_cs[en] = 0; en++;
        exp_op[en] = 1; exp_ch[en] = c; exp_cs[en] = 1; en++;
      end
    end
    d0 = done_cnt;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(init_en_o && !dram_rst_n_o && !cke_o && busy_o, "R2", "pins right after start",
        int'({init_en_o, dram_rst_n_o, cke_o, busy_o}), 9);
    if (poke) begin
      while (!dram_rst_n_o) @(negedge clk);
      repeat (3) @(negedge clk);
      start_i = 1;
      @(negedge clk) start_i = 0;
      chk(dram_rst_n_o && busy_o, "R12", "pin kept during busy start", int'(dram_rst_n_o), 1);
    end
    while (done_cnt == d0) @(negedge clk);
    chk(rst_rise - ea_cyc == CYC_R, "R2", "reset release delay", rst_rise - ea_cyc, CYC_R);
    chk(cke_rise - rst_rise == CYC_C, "R3", "cke delay", cke_rise - rst_rise, CYC_C);
    chk(bad_req == 0, "R4", "requests while cke low", bad_req, 0);
    chk(unstable == 0, "R10", "request field changes", unstable, 0);
    chk(log_n == en, "R6", "request count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++) begin
      chk(log_op[i] == exp_op[i] && log_ch[i] == exp_ch[i] && log_cs[i] == exp_cs[i],
          exp_op[i] ? "R9" : (reg_dimm ? "R6" : "R7"), $sformatf("req %0d op/ch/cs", i),
          log_op[i]*100 + log_ch[i]*10 + log_cs[i], exp_op[i]*100 + exp_ch[i]*10 + exp_cs[i]);
      if (i == 0) begin
        chk(log_start[0] - cke_rise >= CYC_M && log_start[0] - cke_rise <= CYC_M + 3,
            "R4", "first request delay", log_start[0] - cke_rise, CYC_M);
      end else if (log_op[i-1] == 0) begin
        chk(log_start[i] - (log_done[i-1] + 1) >= CYC_D &&
            log_start[i] - (log_done[i-1] + 1) <= CYC_D + 3,
            "R8", "relock gap", log_start[i] - (log_done[i-1] + 1), CYC_D);
      end
    end
    @(negedge clk);
    chk(!busy_o && !done_o && dram_rst_n_o && cke_o && !init_en_o, "R11", "end state",
        int'({busy_o, done_o, dram_rst_n_o, cke_o, init_en_o}), 6);
    repeat (20) @(negedge clk);
    chk(done_cnt - d0 == 1 && !busy_o, "R12", "single done, idle after",
        done_cnt - d0, 1);
  endtask

  initial begin
    ea_cyc = 0; rst_rise = -1; cke_rise = -1; done_cnt = 0; bad_req = 0; unstable = 0; log_n = 0;
    t_reset();
    t_run("registered_all_ranks", 1'b1, 2'b11, {8'b0001_0010, 8'b1010_0101}, 1'b0);
    t_run("unbuffered_first_rank", 1'b0, 2'b11, {8'b0001_0010, 8'b1010_0101}, 1'b0);
    t_run("skip_empty_channel_R5", 1'b1, 2'b10, {8'b0100_0000, 8'b1111_1111}, 1'b0);
    t_run("no_rank_zq_only", 1'b1, 2'b01, {8'b0000_0000, 8'b0000_0000}, 1'b0);
    t_run("start_while_busy", 1'b0, 2'b01, {8'b0000_0000, 8'b1000_0000}, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule